// File: doc/BRIEF.md
# Read Burst Sequencer for a Double-Data-Rate Memory Device

This block models the device side of a double-data-rate memory read. A READ command names a bank, a starting column and whether the row should be closed afterwards. The block waits for a read latency, which is the sum of an additive latency and a CAS latency. It then streams a burst of 4 or 8 data elements out of a small internal array, two elements per clock cycle.

The double-rate pins are modelled as two lanes in a single clock domain. The rising lane carries the element that belongs to the rising clock edge, and the falling lane carries the element that belongs to the falling edge. Each lane has its own strobe level and strobe complement. A data output-enable and a strobe output-enable stand in for the tri-state pads. The block drives the strobe preamble before a burst and flags the postamble on the final beat. It pulses a precharge-done indication when auto-precharge was requested. READs spaced exactly half a burst length apart chain into one unbroken stream.

The internal array is loaded through a plain write port, so every output element can be predicted. Configuration may only change while the block is idle.

Top module: `rdburst_seq`

## Requirements
- R1: A READ is taken when `cmd_rd` is high and the spacing rule of R10 is met. `cmd_bank` is the bank, `cmd_addr[9:0]` is the start column, and `cmd_addr[10]` = 1 requests auto-precharge.
- R2: With RL = `cfg_al` + `cfg_cl` (AL 0..4, CL 3..5), the first data cycle is the RL-th clock cycle after the edge that takes the READ. `dq_oe` is high for exactly BL/2 consecutive cycles.
- R3: In data cycle j (j from 0), the rising lane carries element 2j and the falling lane carries element 2j+1. `rise_dqs` = 1 and `fall_dqs` = 0 in every data cycle.
- R4: `cfg_bl8` = 1 selects BL 8 and 0 selects BL 4. Element k reads column {start[9:b], (start[b-1:0] + k) mod BL}, where b = log2(BL), so the column wraps inside the aligned block.
- R5: In the cycle just before a burst that does not directly follow another burst, `preamble` = 1, `dqs_oe` = 1, both strobes are 0 and `dq_oe` = 0.
- R6: `postamble` = 1 during the last data cycle of a burst exactly when no data follows in the next cycle.
- R7: While idle, `dq_oe` = 0, `dqs_oe` = 0, both data lanes read 0 and both strobes are 0.
- R8: For a burst with auto-precharge, `pch_done` pulses for one cycle in the cycle after its last data cycle, with `pch_bank` set to the burst's bank. Without auto-precharge there is no pulse.
- R9: A READ taken exactly BL/2 cycles after the previous one continues the stream with no idle cycle, no postamble and no preamble between the two bursts.
- R10: A READ fewer than BL/2 cycles after the last taken READ is dropped: it produces no data, and `rd_err` is 1 in the next cycle only.
- R11: The array has 64 entries of 8 bits and is written through `wr_en`/`wr_bank`/`wr_col`/`wr_data`. A column c reads entry {bank, c[3:0] ^ c[7:4] ^ {2'b00, c[9:8]}}.
- R12: `rise_dqs_n` and `fall_dqs_n` are always the inverse of `rise_dqs` and `fall_dqs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_al | input | 3 | Additive latency |
| cfg_cl | input | 3 | CAS latency |
| cfg_bl8 | input | 1 | 1: burst of 8, 0: burst of 4 |
| wr_en | input | 1 | Array write strobe |
| wr_bank | input | 2 | Array write bank |
| wr_col | input | 4 | Array write entry within bank |
| wr_data | input | 8 | Array write value |
| cmd_rd | input | 1 | READ command |
| cmd_bank | input | 2 | READ bank |
| cmd_addr | input | 11 | Start column [9:0], auto-precharge [10] |
| dq_oe | output | 1 | Data lanes driven |
| rise_dq | output | 8 | Rising-edge data element |
| fall_dq | output | 8 | Falling-edge data element |
| dqs_oe | output | 1 | Strobe driven |
| rise_dqs | output | 1 | Strobe level, rising half |
| fall_dqs | output | 1 | Strobe level, falling half |
| rise_dqs_n | output | 1 | Strobe complement, rising half |
| fall_dqs_n | output | 1 | Strobe complement, falling half |
| preamble | output | 1 | Strobe preamble cycle |
| postamble | output | 1 | Final data cycle before idle |
| pch_done | output | 1 | Auto-precharge completed |
| pch_bank | output | 2 | Bank that was precharged |
| rd_err | output | 1 | Early READ was dropped |

## Verification
The bench targets the seam between two bursts. With READs spaced exactly BL/2 apart, a design that inserts a postamble, a preamble or an idle cycle breaks the stream. With one extra cycle of spacing, a design that omits them is caught. Start columns near the top of an aligned block expose wrap errors, where a design carries into the upper column bits or uses the wrong burst-length mask. The bench also covers the smallest and largest latency sums and a READ that arrives too early. An off-by-one latency tap, a design that streams the dropped READ, or one that misplaces the precharge pulse or its bank each shows up as a mismatch in a specific cycle.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  parameter int BANK_W    = 2;
  parameter int COL_W     = 10;
  parameter int ARR_COL_W = 4;
  parameter int DATA_W    = 8;
  parameter int BL_MAX    = 8;
  parameter int BL_MIN    = 4;
  parameter int AL_W      = 3;
  parameter int CL_W      = 3;
  parameter int RL_MAX    = 9;

  typedef struct packed {
    logic              vld;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic              ap;
    logic              bl8;
  } rd_cmd_t;

  // fold the upper column bits onto the array entry index
  function automatic logic [ARR_COL_W-1:0] arr_col(input logic [COL_W-1:0] col);
    logic [ARR_COL_W-1:0] f;
    f = col[ARR_COL_W-1:0];
    for (int i = ARR_COL_W; i < COL_W; i++) f[i % ARR_COL_W] ^= col[i];
    return f;
  endfunction
endpackage

// File: rtl/rdseq_cmd_gate.sv
module rdseq_cmd_gate
  import rdseq_pkg::*;
#(
  parameter int HALF_MAX = BL_MAX / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W:0]    cmd_addr,
  input  logic              bl8,
  output rd_cmd_t           acc,
  output logic              err
);
  localparam int CNT_W = $clog2(HALF_MAX + 1);
  localparam logic [CNT_W-1:0] NEED_L = CNT_W'(HALF_MAX);
  localparam logic [CNT_W-1:0] NEED_S = CNT_W'(BL_MIN / 2);

  logic [CNT_W-1:0] since_q, since_d;
  logic             err_q, err_d;
  logic             spaced;

  always_comb begin
    spaced   = since_q >= (bl8 ? NEED_L : NEED_S);
    acc.vld  = cmd_rd && spaced;
    acc.bank = cmd_bank;
    acc.col  = cmd_addr[COL_W-1:0];
    acc.ap   = cmd_addr[COL_W];
    acc.bl8  = bl8;
    err_d    = cmd_rd && !spaced;
    if (acc.vld)               since_d = CNT_W'(1);
    else if (since_q < NEED_L) since_d = since_q + CNT_W'(1);
    else                       since_d = since_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= NEED_L;
      err_q   <= 1'b0;
    end else begin
      since_q <= since_d;
      err_q   <= err_d;
    end
  end

  assign err = err_q;

  AST_ERR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(cmd_rd)); // R10
endmodule

// File: rtl/rdseq_lat_line.sv
module rdseq_lat_line
  import rdseq_pkg::*;
#(
  parameter int DEPTH = RL_MAX,
  parameter int RL_W  = $clog2(RL_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rd_cmd_t         cmd_in,
  input  logic [RL_W-1:0] rl,
  output logic            head_vld,
  output rd_cmd_t         tap_start,
  output logic            tap_pre_vld
);
  rd_cmd_t dl_q [DEPTH];
  rd_cmd_t dl_d [DEPTH];

  always_comb begin
    dl_d[0] = cmd_in;
    for (int i = 1; i < DEPTH; i++) dl_d[i] = dl_q[i-1];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dl_q[g] <= '0;
      else        dl_q[g] <= dl_d[g];
    end
  end

  // stage i holds a command taken i+1 edges ago
  always_comb begin
    tap_start   = '0;
    tap_pre_vld = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (RL_W'(i + 1) == rl) tap_start   = dl_q[i];
      if (RL_W'(i + 2) == rl) tap_pre_vld = dl_q[i].vld;
    end
  end

  assign head_vld = dl_q[0].vld;
endmodule

// File: rtl/rdseq_data_array.sv
module rdseq_data_array
  import rdseq_pkg::*;
#(
  parameter int IDX_W = BANK_W + ARR_COL_W,
  parameter int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr_a,
  input  logic [IDX_W-1:0]  raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/rdseq_burst_eng.sv
module rdseq_burst_eng
  import rdseq_pkg::*;
#(
  parameter int OFF_W  = $clog2(BL_MAX),
  parameter int BEAT_W = $clog2(BL_MAX / 2),
  parameter int IDX_W  = BANK_W + ARR_COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_cmd_t           tap_start,
  input  logic              tap_pre_vld,
  input  logic [DATA_W-1:0] rd_rise,
  input  logic [DATA_W-1:0] rd_fall,
  output logic [IDX_W-1:0]  raddr_rise,
  output logic [IDX_W-1:0]  raddr_fall,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rise_dq,
  output logic [DATA_W-1:0] fall_dq,
  output logic              dqs_oe,
  output logic              rise_dqs,
  output logic              fall_dqs,
  output logic              rise_dqs_n,
  output logic              fall_dqs_n,
  output logic              preamble,
  output logic              postamble,
  output logic              pch_done,
  output logic [BANK_W-1:0] pch_bank
);
  function automatic logic [BEAT_W-1:0] last_beat(input logic bl8);
    return bl8 ? BEAT_W'(BL_MAX / 2 - 1) : BEAT_W'(BL_MIN / 2 - 1);
  endfunction

  function automatic logic [COL_W-1:0] burst_col(input logic [COL_W-1:0] start,
                                                 input logic [OFF_W-1:0] off,
                                                 input logic bl8);
    logic [OFF_W-1:0] msk, lo, sum;
    msk = bl8 ? OFF_W'(BL_MAX - 1) : OFF_W'(BL_MIN - 1);
    lo  = start[OFF_W-1:0];
    sum = lo + off;
    return {start[COL_W-1:OFF_W], (sum & msk) | (lo & ~msk)};
  endfunction

  // burst state
  logic              act_q, act_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic              ap_q, ap_d, bl8_q, bl8_d;
  // output registers
  logic              dq_oe_q, dqs_oe_q, rdqs_q, fdqs_q, rdqs_n_q, fdqs_n_q;
  logic              pre_q, post_q, pch_q;
  logic [DATA_W-1:0] rdq_q, fdq_q;
  logic [BANK_W-1:0] pchb_q;
  logic              pre_d, post_d, pch_d, end_now;
  logic [BANK_W-1:0] pchb_d;
  logic [OFF_W-1:0]  off_r, off_f;

  always_comb begin
    act_d  = act_q;
    beat_d = beat_q;
    bank_d = bank_q;
    col_d  = col_q;
    ap_d   = ap_q;
    bl8_d  = bl8_q;
    end_now = act_q && (beat_q == last_beat(bl8_q));
    if (tap_start.vld) begin
      act_d  = 1'b1;
      beat_d = '0;
      bank_d = tap_start.bank;
      col_d  = tap_start.col;
      ap_d   = tap_start.ap;
      bl8_d  = tap_start.bl8;
    end else if (act_q && !end_now) begin
      beat_d = beat_q + BEAT_W'(1);
    end else begin
      act_d = 1'b0;
    end
    off_r      = {beat_d, 1'b0};
    off_f      = {beat_d, 1'b1};
    raddr_rise = {bank_d, arr_col(burst_col(col_d, off_r, bl8_d))};
    raddr_fall = {bank_d, arr_col(burst_col(col_d, off_f, bl8_d))};
    // tap_pre_vld now equals the start tap one edge later
    pre_d  = tap_pre_vld && !act_d;
    post_d = act_d && (beat_d == last_beat(bl8_d)) && !tap_pre_vld;
    pch_d  = end_now && ap_q;
    pchb_d = bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      bank_q <= '0;
      col_q  <= '0;
      ap_q   <= 1'b0;
      bl8_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      beat_q <= beat_d;
      bank_q <= bank_d;
      col_q  <= col_d;
      ap_q   <= ap_d;
      bl8_q  <= bl8_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe_q  <= 1'b0;
      dqs_oe_q <= 1'b0;
      rdq_q    <= '0;
      fdq_q    <= '0;
      rdqs_q   <= 1'b0;
      fdqs_q   <= 1'b0;
      rdqs_n_q <= 1'b1;
      fdqs_n_q <= 1'b1;
      pre_q    <= 1'b0;
      post_q   <= 1'b0;
      pch_q    <= 1'b0;
      pchb_q   <= '0;
    end else begin
      dq_oe_q  <= act_d;
      dqs_oe_q <= act_d || pre_d;
      rdq_q    <= act_d ? rd_rise : '0;
      fdq_q    <= act_d ? rd_fall : '0;
      rdqs_q   <= act_d;
      fdqs_q   <= 1'b0;
      rdqs_n_q <= !act_d;
      fdqs_n_q <= 1'b1;
      pre_q    <= pre_d;
      post_q   <= post_d;
      pch_q    <= pch_d;
      if (pch_d) pchb_q <= pchb_d;
    end
  end

  assign dq_oe      = dq_oe_q;
  assign dqs_oe     = dqs_oe_q;
  assign rise_dq    = rdq_q;
  assign fall_dq    = fdq_q;
  assign rise_dqs   = rdqs_q;
  assign fall_dqs   = fdqs_q;
  assign rise_dqs_n = rdqs_n_q;
  assign fall_dqs_n = fdqs_n_q;
  assign preamble   = pre_q;
  assign postamble  = post_q;
  assign pch_done   = pch_q;
  assign pch_bank   = pchb_q;

  AST_PRE_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe_q) |-> $past(pre_q)); // R5
  AST_POST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    post_q |=> !dq_oe_q); // R6
  AST_STROBE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_q |-> (dqs_oe_q && rdqs_q && !fdqs_q)); // R3
  AST_PCH_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pch_q |-> $past(dq_oe_q)); // R8
  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (beat_q <= last_beat(bl8_q))); // R3
  AST_DQS_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (rdqs_n_q == !rdqs_q) && (fdqs_n_q == !fdqs_q)); // R12
endmodule

// File: rtl/rdburst_seq.sv
module rdburst_seq
  import rdseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AL_W-1:0]      cfg_al,
  input  logic [CL_W-1:0]      cfg_cl,
  input  logic                 cfg_bl8,
  input  logic                 wr_en,
  input  logic [BANK_W-1:0]    wr_bank,
  input  logic [ARR_COL_W-1:0] wr_col,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 cmd_rd,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [COL_W:0]       cmd_addr,
  output logic                 dq_oe,
  output logic [DATA_W-1:0]    rise_dq,
  output logic [DATA_W-1:0]    fall_dq,
  output logic                 dqs_oe,
  output logic                 rise_dqs,
  output logic                 fall_dqs,
  output logic                 rise_dqs_n,
  output logic                 fall_dqs_n,
  output logic                 preamble,
  output logic                 postamble,
  output logic                 pch_done,
  output logic [BANK_W-1:0]    pch_bank,
  output logic                 rd_err
);
  localparam int RL_W  = $clog2(RL_MAX + 1);
  localparam int IDX_W = BANK_W + ARR_COL_W;

  // reset: asserted at once, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [RL_W-1:0]   rl;
  rd_cmd_t           acc, tap_start;
  logic              head_vld, tap_pre_vld;
  logic [IDX_W-1:0]  raddr_rise, raddr_fall;
  logic [DATA_W-1:0] rd_rise, rd_fall;

  assign rl = RL_W'(cfg_al) + RL_W'(cfg_cl);

  rdseq_cmd_gate u_gate (
    .clk(clk), .rst_n(rst_sync_q), .cmd_rd(cmd_rd), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .bl8(cfg_bl8), .acc(acc), .err(rd_err)
  );

  rdseq_lat_line #(.DEPTH(RL_MAX), .RL_W(RL_W)) u_lat (
    .clk(clk), .rst_n(rst_sync_q), .cmd_in(acc), .rl(rl),
    .head_vld(head_vld), .tap_start(tap_start), .tap_pre_vld(tap_pre_vld)
  );

  rdseq_data_array #(.IDX_W(IDX_W)) u_arr (
    .clk(clk), .we(wr_en), .waddr({wr_bank, wr_col}), .wdata(wr_data),
    .raddr_a(raddr_rise), .raddr_b(raddr_fall),
    .rdata_a(rd_rise), .rdata_b(rd_fall)
  );

  rdseq_burst_eng u_eng (
    .clk(clk), .rst_n(rst_sync_q), .tap_start(tap_start), .tap_pre_vld(tap_pre_vld),
    .rd_rise(rd_rise), .rd_fall(rd_fall),
    .raddr_rise(raddr_rise), .raddr_fall(raddr_fall),
    .dq_oe(dq_oe), .rise_dq(rise_dq), .fall_dq(fall_dq), .dqs_oe(dqs_oe),
    .rise_dqs(rise_dqs), .fall_dqs(fall_dqs),
    .rise_dqs_n(rise_dqs_n), .fall_dqs_n(fall_dqs_n),
    .preamble(preamble), .postamble(postamble),
    .pch_done(pch_done), .pch_bank(pch_bank)
  );

  AST_ERR_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_q)
    rd_err |-> !head_vld); // R10
endmodule

// File: tb/rdburst_seq_test.sv
module rdburst_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_al, cfg_cl;
  logic        cfg_bl8;
  logic        wr_en;
  logic [1:0]  wr_bank;
  logic [3:0]  wr_col;
  logic [7:0]  wr_data;
  logic        cmd_rd;
  logic [1:0]  cmd_bank;
  logic [10:0] cmd_addr;
  logic        dq_oe, dqs_oe, rise_dqs, fall_dqs, rise_dqs_n, fall_dqs_n;
  logic        preamble, postamble, pch_done, rd_err;
  logic [7:0]  rise_dq, fall_dq;
  logic [1:0]  pch_bank;

  always #10 clk = ~clk;

  rdburst_seq uut (.*);

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [7:0] mem_m [64];
  int         ncmd;
  int         c_at [4];
  logic [1:0] c_bank [4];
  logic [9:0] c_col [4];
  logic       c_ap [4];
  bit         e_v [48];
  logic [7:0] e_r [48], e_f [48];
  bit         e_err [48], e_pd [48];
  logic [1:0] e_pdb [48];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int idx(input logic [1:0] b, input logic [9:0] col, input int k, input bit bl8);
    logic [2:0] lo, m, w;
    logic [9:0] c;
    lo = col[2:0];
    m  = bl8 ? 3'd7 : 3'd3;
    w  = ((lo + 3'(k)) & m) | (lo & ~m);
    c  = {col[9:3], w};
    return int'(b) * 16 + int'(c[3:0] ^ c[7:4] ^ {2'b00, c[9:8]});
  endfunction

  task automatic mem_write(input int i, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1; wr_bank = 2'(i / 16); wr_col = 4'(i % 16); wr_data = v;
    mem_m[i] = v;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic setcfg(input int al, input int cl, input bit bl8);
    cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl8 = bl8; ncmd = 0;
  endtask

  task automatic add_cmd(input int at, input logic [1:0] b, input logic [9:0] col, input logic ap);
    c_at[ncmd] = at; c_bank[ncmd] = b; c_col[ncmd] = col; c_ap[ncmd] = ap; ncmd++;
  endtask

  // build the expected timeline from the requirements; a command driven in
  // iteration c is taken at edge c+1
  task automatic build();
    int rl, half, last;
    rl = int'(cfg_al) + int'(cfg_cl);
    half = cfg_bl8 ? 4 : 2;
    last = -100;
    for (int c = 0; c < 48; c++) begin
      e_v[c] = 0; e_r[c] = 0; e_f[c] = 0; e_err[c] = 0; e_pd[c] = 0; e_pdb[c] = 0;
    end
    for (int i = 0; i < ncmd; i++) begin
      int e;
      e = c_at[i] + 1;
      if (e - last >= half) begin
        last = e;
        for (int j = 0; j < half; j++) begin
          e_v[e + rl + j] = 1;
          e_r[e + rl + j] = mem_m[idx(c_bank[i], c_col[i], 2 * j, cfg_bl8)];
          e_f[e + rl + j] = mem_m[idx(c_bank[i], c_col[i], 2 * j + 1, cfg_bl8)];
        end
        if (c_ap[i]) begin
          e_pd[e + rl + half] = 1;
          e_pdb[e + rl + half] = c_bank[i];
        end
      end else begin
        e_err[e] = 1;
      end
    end
  endtask

  task automatic run(input int ncyc, input string dtag);
    build();
    for (int c = 0; c < ncyc; c++) begin
      bit pre_e, post_e;
      @(negedge clk);
      pre_e  = !e_v[c] && e_v[c + 1];
      post_e = e_v[c] && !e_v[c + 1];
      chk(dq_oe == e_v[c], "R2/R7 dq_oe", dq_oe, e_v[c]);
      if (e_v[c]) begin
        chk(rise_dq == e_r[c], {dtag, " rise_dq"}, rise_dq, e_r[c]);
        chk(fall_dq == e_f[c], {dtag, " fall_dq"}, fall_dq, e_f[c]);
        chk(rise_dqs && !fall_dqs, "R3 strobe in data", {rise_dqs, fall_dqs}, 2);
      end else begin
        chk(rise_dq == 0 && fall_dq == 0, "R7 idle data", {rise_dq, fall_dq}, 0);
        chk(!rise_dqs && !fall_dqs, "R5/R7 strobe low", {rise_dqs, fall_dqs}, 0);
      end
      chk(dqs_oe == (e_v[c] || pre_e), "R5 dqs_oe", dqs_oe, e_v[c] || pre_e);
      chk(preamble == pre_e, "R5 preamble", preamble, pre_e);
      chk(postamble == post_e, "R6 postamble", postamble, post_e);
      chk(rise_dqs_n == !rise_dqs && fall_dqs_n == !fall_dqs, "R12 complement",
          {rise_dqs_n, fall_dqs_n}, {!rise_dqs, !fall_dqs});
      chk(rd_err == e_err[c], "R10 rd_err", rd_err, e_err[c]);
      chk(pch_done == e_pd[c], "R8 pch_done", pch_done, e_pd[c]);
      if (e_pd[c]) chk(pch_bank == e_pdb[c], "R8 pch_bank", pch_bank, e_pdb[c]);
      cmd_rd = 0;
      for (int i = 0; i < ncmd; i++)
        if (c_at[i] == c) begin
          cmd_rd = 1; cmd_bank = c_bank[i]; cmd_addr = {c_ap[i], c_col[i]};
        end
    end
    cmd_rd = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!dq_oe && !dqs_oe, "R7 reset oe", {dq_oe, dqs_oe}, 0);
    chk(rise_dq == 0 && fall_dq == 0, "R7 reset data", {rise_dq, fall_dq}, 0);
    chk(!rd_err && !pch_done && !preamble && !postamble, "R7 reset flags",
        {rd_err, pch_done, preamble, postamble}, 0);
    chk(rise_dqs_n && fall_dqs_n, "R12 reset complement", {rise_dqs_n, fall_dqs_n}, 3);
  endtask

  // R1 R2: smallest latency, BL 4, no auto-precharge
  task automatic t_single();
    setcfg(0, 3, 0); add_cmd(2, 2'd1, 10'h005, 1'b0); run(16, "R1");
  endtask

  // R4 R8: BL 8 wrap near the top of the column range, auto-precharge
  task automatic t_wrap_ap();
    setcfg(2, 4, 1); add_cmd(2, 2'd2, 10'h3F6, 1'b1); run(22, "R4");
  endtask

  // R9: chained bursts in both lengths
  task automatic t_gapless();
    setcfg(1, 3, 0);
    add_cmd(2, 2'd0, 10'h008, 1'b0); add_cmd(4, 2'd3, 10'h002, 1'b1);
    add_cmd(6, 2'd1, 10'h0F1, 1'b1);
    run(22, "R9");
    setcfg(0, 4, 1);
    add_cmd(2, 2'd3, 10'h10D, 1'b1); add_cmd(6, 2'd2, 10'h047, 1'b0);
    run(24, "R9");
  endtask

  // R6 R5: one spare cycle forces postamble then preamble
  task automatic t_gap();
    setcfg(0, 3, 0);
    add_cmd(2, 2'd2, 10'h013, 1'b0); add_cmd(5, 2'd0, 10'h2C0, 1'b1);
    run(20, "R3");
  endtask

  // R10: an early READ is dropped, the next spaced one is served
  task automatic t_early();
    setcfg(1, 3, 1);
    add_cmd(2, 2'd1, 10'h021, 1'b0); add_cmd(4, 2'd3, 10'h030, 1'b1);
    add_cmd(6, 2'd0, 10'h00E, 1'b0);
    run(24, "R10");
  endtask

  // R2: largest latency sum
  task automatic t_maxlat();
    setcfg(4, 5, 1); add_cmd(2, 2'd3, 10'h3FF, 1'b1); run(26, "R2");
  endtask

  // R11: upper column bits fold onto the entry index; rewritten entry is read
  task automatic t_alias();
    mem_write(0 * 16 + (4'h3 ^ 4'hF ^ 4'h3), 8'hC3);
    setcfg(0, 5, 0); add_cmd(2, 2'd0, 10'h3F3, 1'b0); run(16, "R11");
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_bank = 0; wr_col = 0; wr_data = 0;
    cmd_rd = 0; cmd_bank = 0; cmd_addr = 0; ncmd = 0;
    cfg_al = 0; cfg_cl = 3; cfg_bl8 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    for (int i = 0; i < 64; i++) mem_write(i, 8'(i * 7 + 3));
    t_single();
    t_wrap_ap();
    t_gapless();
    t_gap();
    t_early();
    t_maxlat();
    t_alias();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule